// File: doc/BRIEF.md
# Byte ALU with Excess-128 Arithmetic and Sequenced Divide

This block is the arithmetic and logic unit of a small byte-wide controller. On a start strobe it takes an opcode, two byte operands, a bit index and, for division, a two-byte dividend. It returns one or two result bytes, a one-cycle done pulse and two flags, Carry and Sign.

Most operations finish in a single cycle. These are add and subtract, the bitwise logic operations, single-bit set, clear and test, one-place shifts and rotates, and an 8x8 multiply. Offset add and offset subtract keep signed quantities in excess-128 form: the sum has 128 taken away and the difference has 128 added, so a byte holds a value from -128 to 127. Division runs a restoring shift-and-subtract loop over sixteen cycles. The remainder is returned in the high result byte and the quotient in the low one, so that the caller can write them back over the two bytes that held the dividend.

Top module: `byte_alu`

## Requirements
- R1: Opcode 0 (add) gives res_lo = (opa+opb) mod 256 and res_hi = 0. Carry is bit 8 of the sum and Sign is cleared.
- R2: Opcode 1 (subtract) gives res_lo = (opa-opb) mod 256 and res_hi = 0. Sign is set exactly when opa < opb and Carry is cleared.
- R3: Opcodes 2, 3 and 4 give opa AND opb, opa OR opb and opa XOR opb in res_lo, with res_hi = 0. Carry and Sign keep their previous values.
- R4: Opcode 5 sets and opcode 6 clears bit bit_sel (0 = LSB) of opa, and the result goes to res_lo. Flags are unchanged.
- R5: Opcode 7 (bit test) gives res_lo = 8'h01 when bit bit_sel of opa is 1 and 8'h00 when it is 0. Carry and Sign are unchanged.
- R6: Opcodes 8, 9, 10 and 11 are shift left, shift right, rotate left and rotate right of opa by one place. The shifts fill with zero. Flags are unchanged.
- R7: Opcode 12 (offset add) computes t = opa+opb-128 and gives res_lo = t mod 256. Carry is set when t > 255 and Sign is set when t < 0.
- R8: Opcode 13 (offset subtract) computes t = opa-opb+128 and gives res_lo = t mod 256. Carry is set when t > 255 and Sign is set when t < 0.
- R9: Opcode 14 gives {res_hi,res_lo} = opa*opb and clears both flags.
- R10: Opcode 15 divides {div_hi,div_lo} by opb. res_hi holds the remainder and res_lo the quotient, and Sign is cleared. A quotient above 255 gives res_lo = 8'hFF with Carry set; otherwise Carry is cleared.
- R11: A divide by zero gives res_lo = 8'hFF and res_hi = div_lo, and sets Carry.
- R12: For a non-divide start, the results and a one-cycle done pulse appear after the accepting clock edge. For a divide, done rises 16 edges after the accepting edge, stays low until then, and lasts one cycle.
- R13: A start that arrives while a divide is in progress is ignored. The outputs stay unchanged until the divide result appears.
- R14: Synchronous reset clears res_hi, res_lo, Carry, Sign and done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the operation selected by op |
| op | input | 4 | Opcode 0..15 |
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand; divisor for divide |
| div_hi | input | 8 | Dividend high byte |
| div_lo | input | 8 | Dividend low byte |
| bit_sel | input | 3 | Bit index for set, clear and test |
| res_hi | output | 8 | High result byte: product high or remainder |
| res_lo | output | 8 | Low result byte: result, product low or quotient |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Overflow flag |
| sign | output | 1 | Underflow flag |

## Verification
The assertions assume that start, op and the operands hold known values and stay steady around each rising edge. They also assume that the caller waits for done before relying on the next result. The only exception is the deliberate overlapping start that exercises the busy window. The bench changes every input on the falling edge and releases start one cycle after raising it. The overlapping start it sends during a divide is the only stimulus that breaks the one-operation-at-a-time pattern.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_BSET = 4'd5,
    OP_BCLR = 4'd6,
    OP_BTST = 4'd7,
    OP_SHL  = 4'd8,
    OP_SHR  = 4'd9,
    OP_ROL  = 4'd10,
    OP_ROR  = 4'd11,
    OP_ADDO = 4'd12,
    OP_SUBO = 4'd13,
    OP_MUL  = 4'd14,
    OP_DIV  = 4'd15
  } alu_op_e;

  function automatic logic is_arith(alu_op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_ADDO) ||
           (o == OP_SUBO) || (o == OP_MUL);
  endfunction
endpackage

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  y
);
  logic [W-1:0] mask;
  assign mask = W'(1) << idx;

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_BSET: y = a | mask;
      OP_BCLR: y = a & ~mask;
      OP_BTST: y = W'(|(a & mask));
      OP_SHL:  y = {a[W-2:0], 1'b0};
      OP_SHR:  y = {1'b0, a[W-1:1]};
      OP_ROL:  y = {a[W-2:0], a[W-1]};
      OP_ROR:  y = {a[0], a[W-1:1]};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y_hi,
  output logic [W-1:0] y_lo,
  output logic         cy,
  output logic         sg
);
  localparam int EW = W + 2;
  localparam logic [EW-1:0] BIAS = EW'(1) << (W - 1);

  logic [EW-1:0]  ax, bx, t;
  logic [2*W-1:0] prod;
  logic           mul;

  assign ax   = {2'b00, a};
  assign bx   = {2'b00, b};
  assign prod = a * b;
  assign mul  = (op == OP_MUL);

  always_comb begin
    case (op)
      OP_ADD:  t = ax + bx;
      OP_SUB:  t = ax - bx;
      OP_ADDO: t = ax + bx - BIAS;
      OP_SUBO: t = ax - bx + BIAS;
      default: t = '0;
    endcase
  end

  assign y_lo = mul ? prod[W-1:0]   : t[W-1:0];
  assign y_hi = mul ? prod[2*W-1:W] : '0;
  assign cy   = mul ? 1'b0 : (~t[EW-1] & t[W]);
  assign sg   = mul ? 1'b0 : t[EW-1];
endmodule

// File: rtl/byte_alu_div.sv
module byte_alu_div #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [2*W-1:0] dvd,
  input  logic [W-1:0]   dvs,
  output logic           busy,
  output logic           last,
  output logic [W-1:0]   q,
  output logic [W-1:0]   r,
  output logic           ovf
);
  localparam int NSTEP = 2 * W;
  localparam int CW    = $clog2(NSTEP);

  logic [CW-1:0]  cnt;
  logic [W-1:0]   rem_r, dvs_r, lo_r, rem_n;
  logic [2*W-1:0] quo_r, quo_n;
  logic [W:0]     shifted;
  logic           fits, zdiv, big;

  assign shifted = {rem_r, quo_r[2*W-1]};
  assign fits    = shifted >= {1'b0, dvs_r};
  assign rem_n   = fits ? W'(shifted - {1'b0, dvs_r}) : shifted[W-1:0];
  assign quo_n   = {quo_r[2*W-2:0], fits};
  assign last    = busy && (cnt == CW'(NSTEP - 1));

  assign zdiv = (dvs_r == '0);
  assign big  = |quo_n[2*W-1:W];
  assign q    = (zdiv || big) ? '1 : quo_n[W-1:0];
  assign r    = zdiv ? lo_r : rem_n;
  assign ovf  = zdiv || big;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      rem_r <= '0;
      quo_r <= '0;
      dvs_r <= '0;
      lo_r  <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt   <= '0;
      rem_r <= '0;
      quo_r <= dvd;
      dvs_r <= dvs;
      lo_r  <= dvd[W-1:0];
    end else if (busy) begin
      rem_r <= rem_n;
      quo_r <= quo_n;
      cnt   <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [W-1:0]  div_hi,
  input  logic [W-1:0]  div_lo,
  input  logic [IW-1:0] bit_sel,
  output logic [W-1:0]  res_hi,
  output logic [W-1:0]  res_lo,
  output logic          done,
  output logic          carry,
  output logic          sign
);
  alu_op_e      opc;
  logic [W-1:0] lg_y, ar_hi, ar_lo, dq, dr;
  logic         ar_cy, ar_sg, div_busy, div_last, div_ovf;
  logic         accept, div_go;

  assign opc    = alu_op_e'(op);
  assign accept = start && !div_busy;
  assign div_go = accept && (opc == OP_DIV);

  byte_alu_logic #(.W(W)) u_logic (
    .op(opc), .a(opa), .b(opb), .idx(bit_sel), .y(lg_y)
  );

  byte_alu_arith #(.W(W)) u_arith (
    .op(opc), .a(opa), .b(opb),
    .y_hi(ar_hi), .y_lo(ar_lo), .cy(ar_cy), .sg(ar_sg)
  );

  byte_alu_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .go(div_go),
    .dvd({div_hi, div_lo}), .dvs(opb),
    .busy(div_busy), .last(div_last), .q(dq), .r(dr), .ovf(div_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_hi <= '0;
      res_lo <= '0;
      done   <= 1'b0;
      carry  <= 1'b0;
      sign   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (div_last) begin
        res_hi <= dr;
        res_lo <= dq;
        carry  <= div_ovf;
        sign   <= 1'b0;
        done   <= 1'b1;
      end else if (accept && (opc != OP_DIV)) begin
        done <= 1'b1;
        if (is_arith(opc)) begin
          res_hi <= ar_hi;
          res_lo <= ar_lo;
          carry  <= ar_cy;
          sign   <= ar_sg;
        end else begin
          res_hi <= '0;
          res_lo <= lg_y;
        end
      end
    end
  end
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int W = 8,
  localparam int IW = $clog2(W)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    op,
  input logic [W-1:0]  opa,
  input logic [W-1:0]  opb,
  input logic [IW-1:0] bit_sel,
  input logic [W-1:0]  res_hi,
  input logic [W-1:0]  res_lo,
  input logic          done,
  input logic          carry,
  input logic          sign,
  input logic          div_busy,
  input logic          div_last
);
  logic [W:0]     chk_sum;
  logic [2*W-1:0] chk_prod;
  logic           go_now;

  assign chk_sum  = {1'b0, opa} + {1'b0, opb};
  assign chk_prod = opa * opb;
  assign go_now   = start && !div_busy;

  a_r12_single_done: assert property (@(posedge clk) disable iff (rst)
    (go_now && op != 4'd15) |=> done);

  a_r12_no_early_done: assert property (@(posedge clk) disable iff (rst)
    (div_busy && !div_last) |=> !done);

  a_r13_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    (div_busy && !div_last) |=> ($stable(res_hi) && $stable(res_lo)));

  a_r1_add_carry: assert property (@(posedge clk) disable iff (rst)
    (go_now && op == 4'd0) |=> (carry == $past(chk_sum[W]) && !sign));

  a_r5_btst_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (go_now && op == 4'd7) |=>
      (carry == $past(carry) && sign == $past(sign) &&
       res_lo == W'($past(opa[bit_sel]))));

  a_r9_mul_product: assert property (@(posedge clk) disable iff (rst)
    (go_now && op == 4'd14) |=> ({res_hi, res_lo} == $past(chk_prod)));

  a_r14_reset_clear: assert property (@(posedge clk)
    rst |=> (res_hi == '0 && res_lo == '0 && !done && !carry && !sign));
endmodule

bind byte_alu byte_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
  .bit_sel(bit_sel), .res_hi(res_hi), .res_lo(res_lo), .done(done),
  .carry(carry), .sign(sign), .div_busy(div_busy), .div_last(div_last)
);

// File: tb/byte_alu_test.sv
module byte_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] opa = '0, opb = '0, div_hi = '0, div_lo = '0;
  logic [2:0] bit_sel = '0;
  logic [7:0] res_hi, res_lo;
  logic       done, carry, sign;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2 clk = ~clk;

  byte_alu uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .div_hi(div_hi), .div_lo(div_lo), .bit_sel(bit_sel),
    .res_hi(res_hi), .res_lo(res_lo), .done(done), .carry(carry), .sign(sign)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [2:0] idx;
    logic [7:0] hi;
    logic [7:0] lo;
    logic       c;
    logic       s;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  4'd0,  8'h30, 8'h40, 3'd0, 8'h00, 8'h70, 1'b0, 1'b0}, // R1
    '{4'd1,  4'd0,  8'hF0, 8'h20, 3'd0, 8'h00, 8'h10, 1'b1, 1'b0}, // R1 carry
    '{4'd3,  4'd2,  8'hF0, 8'h3C, 3'd0, 8'h00, 8'h30, 1'b1, 1'b0}, // R3 flags kept
    '{4'd2,  4'd1,  8'h20, 8'h30, 3'd0, 8'h00, 8'hF0, 1'b0, 1'b1}, // R2 underflow
    '{4'd3,  4'd3,  8'h0F, 8'hA0, 3'd0, 8'h00, 8'hAF, 1'b0, 1'b1}, // R3
    '{4'd3,  4'd4,  8'hFF, 8'h0F, 3'd0, 8'h00, 8'hF0, 1'b0, 1'b1}, // R3
    '{4'd4,  4'd5,  8'h00, 8'h00, 3'd5, 8'h00, 8'h20, 1'b0, 1'b1}, // R4
    '{4'd4,  4'd6,  8'hFF, 8'h00, 3'd0, 8'h00, 8'hFE, 1'b0, 1'b1}, // R4
    '{4'd5,  4'd7,  8'h80, 8'h00, 3'd7, 8'h00, 8'h01, 1'b0, 1'b1}, // R5
    '{4'd5,  4'd7,  8'h80, 8'h00, 3'd6, 8'h00, 8'h00, 1'b0, 1'b1}, // R5
    '{4'd6,  4'd8,  8'h81, 8'h00, 3'd0, 8'h00, 8'h02, 1'b0, 1'b1}, // R6
    '{4'd6,  4'd9,  8'h81, 8'h00, 3'd0, 8'h00, 8'h40, 1'b0, 1'b1}, // R6
    '{4'd6,  4'd10, 8'h81, 8'h00, 3'd0, 8'h00, 8'h03, 1'b0, 1'b1}, // R6
    '{4'd6,  4'd11, 8'h81, 8'h00, 3'd0, 8'h00, 8'hC0, 1'b0, 1'b1}, // R6
    '{4'd2,  4'd1,  8'h50, 8'h10, 3'd0, 8'h00, 8'h40, 1'b0, 1'b0}, // R2
    '{4'd7,  4'd12, 8'h90, 8'h85, 3'd0, 8'h00, 8'h95, 1'b0, 1'b0}, // R7
    '{4'd7,  4'd12, 8'hF0, 8'hF0, 3'd0, 8'h00, 8'h60, 1'b1, 1'b0}, // R7 over
    '{4'd5,  4'd7,  8'h02, 8'h00, 3'd1, 8'h00, 8'h01, 1'b1, 1'b0}, // R5 keeps carry
    '{4'd7,  4'd12, 8'h10, 8'h20, 3'd0, 8'h00, 8'hB0, 1'b0, 1'b1}, // R7 under
    '{4'd8,  4'd13, 8'h90, 8'h85, 3'd0, 8'h00, 8'h8B, 1'b0, 1'b0}, // R8
    '{4'd8,  4'd13, 8'h00, 8'hF0, 3'd0, 8'h00, 8'h90, 1'b0, 1'b1}, // R8 under
    '{4'd8,  4'd13, 8'hF0, 8'h00, 3'd0, 8'h00, 8'h70, 1'b1, 1'b0}, // R8 over
    '{4'd9,  4'd14, 8'hFF, 8'hFF, 3'd0, 8'hFE, 8'h01, 1'b0, 1'b0}, // R9
    '{4'd9,  4'd14, 8'h12, 8'h10, 3'd0, 8'h01, 8'h20, 1'b0, 1'b0}, // R9
    '{4'd1,  4'd0,  8'hFF, 8'h01, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0}, // R1 wrap
    '{4'd2,  4'd1,  8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0}  // R2 equal
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_div(input logic [7:0] h, input logic [7:0] l,
                         input logic [7:0] d, input bit inject);
    logic [15:0] dv;
    logic [15:0] qq;
    logic [7:0]  eq, er;
    logic        ec;
    bit          early;
    dv = {h, l};
    if (d == 8'h00) begin
      eq = 8'hFF; er = l; ec = 1'b1;      // R11
    end else begin
      qq = dv / {8'h00, d};
      er = 8'(dv % {8'h00, d});
      ec = (qq > 16'd255);
      eq = ec ? 8'hFF : qq[7:0];          // R10
    end
    @(negedge clk);
    op = 4'd15; div_hi = h; div_lo = l; opb = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    early = done;
    for (int k = 1; k <= 15; k++) begin
      if (inject && k == 5) begin
        op = 4'd0; opa = 8'h11; opb = 8'h22; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      early = early | done;
      if (inject && k == 6)   // R13 ignored start leaves outputs alone
        check(!done, "R13", {31'd0, done}, 32'd0);
    end
    check(!early, "R12 early done", {31'd0, early}, 32'd0);
    @(negedge clk);
    check(done, "R12 div done", {31'd0, done}, 32'd1);
    check(res_hi == er && res_lo == eq, (d == 0) ? "R11" : "R10",
          {16'd0, res_hi, res_lo}, {16'd0, er, eq});
    check(carry == ec && !sign, "R10 flags", {30'd0, carry, sign}, {30'd0, ec, 1'b0});
    @(negedge clk);
    check(!done, "R12 pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R14 reset state
    check(res_hi == 0 && res_lo == 0 && !done && !carry && !sign, "R14",
          {19'd0, res_hi, res_lo, done, carry, sign}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i].op; opa = VEC[i].a; opb = VEC[i].b; bit_sel = VEC[i].idx;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n_chk++;
      if (!done || res_hi != VEC[i].hi || res_lo != VEC[i].lo ||
          carry != VEC[i].c || sign != VEC[i].s) begin
        n_bad++;
        $display("FAIL R%0d vec %0d actual=%b %h %h %b%b expected=1 %h %h %b%b",
                 VEC[i].req, i, done, res_hi, res_lo, carry, sign,
                 VEC[i].hi, VEC[i].lo, VEC[i].c, VEC[i].s);
      end
    end
    @(negedge clk);
    check(!done, "R12 single pulse", {31'd0, done}, 32'd0);

    run_div(8'h12, 8'h34, 8'h56, 1'b0);  // R10 ordinary
    run_div(8'h00, 8'hFF, 8'h01, 1'b0);  // R10 largest fitting quotient
    run_div(8'h01, 8'h00, 8'h01, 1'b0);  // R10 quotient overflow
    run_div(8'hAB, 8'hCD, 8'h00, 1'b0);  // R11 divide by zero
    run_div(8'h7F, 8'hFF, 8'hFF, 1'b1);  // R13 start during divide

    // R14 reset after activity
    op = 4'd0; opa = 8'hFF; opb = 8'h02; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(res_hi == 0 && res_lo == 0 && !done && !carry && !sign, "R14 mid",
          {19'd0, res_hi, res_lo, done, carry, sign}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule